// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is an SPI slave that presents a small byte-wide memory the way a serial EEPROM does. A host lowers the active-low select, clocks an 8-bit instruction and, where needed, a 16-bit address into the serial input, and then either clocks data in or collects data from the serial output. Every serial line is oversampled by the fast system clock through a synchronizer, so the SPI clock must stay at least four system clocks in each phase. Six instructions are decoded: set and clear of the write-enable latch, array read, array write, status read and status write.

Array writes are collected in a page buffer while select is low. They are committed one byte per system clock after select rises. A write commits only if the write-enable latch was already set by an earlier frame. Each byte is committed only if its address lies outside the region fenced off by the two block-protect bits. The status register carries a protect-enable bit, which gives a write-protect input pin control over status writes. Whenever the device is not shifting data out, the serial output is released to high impedance.

Top module: `spi_ee_top`

## Requirements
- R1: After reset the write-enable latch is 0, the status byte reads 0x00 and the serial output is high impedance.
- R2: Instruction 0x06 sets the write-enable latch and 0x04 clears it, both only when select rises after the full opcode. Any further bits in that frame are ignored, so a write sent in the same frame as 0x06 leaves the array unchanged.
- R3: A write frame (0x02) sent while the latch is 0 leaves the array unchanged.
- R4: Mode 0 timing applies: input is sampled on the rising SPI clock edge and output changes on the falling edge, MSB first. Read (0x03) takes a 16-bit address of which only the low log2(DEPTH) bits are used. The byte at that address appears on the output during the next 8 clocks.
- R5: If clocking continues during a read, the following bytes are returned, and the pointer wraps from DEPTH-1 to 0.
- R6: Status read (0x05) returns {pe, 3'b000, bp[1:0], wel, 1'b0}. Here pe is bit 7, bp is bits 3:2 and wel is bit 1. The byte repeats for as long as clocking continues.
- R7: A write frame is 0x02, then a 16-bit address, then data bytes. At most PAGE whole bytes are kept, for consecutive addresses that wrap at DEPTH-1. Extra bytes and a trailing partial byte are dropped. The kept bytes commit when select rises.
- R8: A byte is never committed to a protected address. bp=0 protects nothing, bp=1 protects the upper quarter, bp=2 the upper half and bp=3 the whole array.
- R9: A status write (0x01, one data byte) updates pe and bp only if the latch is 1 and either pe is 0 or the write-protect pin is high.
- R10: When select rises after a write frame with at least one whole data byte, or after a status write with a whole data byte, the latch clears. This holds whether or not anything was stored.
- R11: The serial output is high impedance whenever select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| sk | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data input |
| wp | input | 1 | Write-protect pin, high allows status writes while protect-enable is set |
| so | output | 1 | Serial data output, high impedance when not driving |

## Verification
The bench builds the block with DEPTH=16 and PAGE=4. At that size every address can be written and read back under each of the four block-protect levels, and a single read can run past the top of the array to show the wrap. With four-byte pages, a six-byte write runs past both the page limit and the array top in one frame. All eight combinations of protect-enable, write-protect pin and latch are driven through a status write, and each result is compared with a value the bench computes.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int SR_PE  = 7;
  localparam int SR_BPH = 3;
  localparam int SR_BPL = 2;

  function automatic logic [7:0] sr_pack(input logic pe, input logic [1:0] bp, input logic wel);
    return {pe, 3'b000, bp, wel, 1'b0};
  endfunction
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sk_i,
  input  logic cs_n_i,
  input  logic si_i,
  input  logic wp_i,
  output logic si_s,
  output logic wp_s,
  output logic cs_n_s,
  output logic sk_rise,
  output logic sk_fall,
  output logic cs_rise
);
  localparam int MS = STAGES - 1;

  logic [MS:0] sk_p, cs_p, si_p, wp_p;
  logic sk_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_p <= '0;
      cs_p <= '1;
      si_p <= '0;
      wp_p <= '0;
      sk_d <= 1'b0;
      cs_d <= 1'b1;
    end else begin
      sk_p <= {sk_p[MS-1:0], sk_i};
      cs_p <= {cs_p[MS-1:0], cs_n_i};
      si_p <= {si_p[MS-1:0], si_i};
      wp_p <= {wp_p[MS-1:0], wp_i};
      sk_d <= sk_p[MS];
      cs_d <= cs_p[MS];
    end
  end

  assign si_s    = si_p[MS];
  assign wp_s    = wp_p[MS];
  assign cs_n_s  = cs_p[MS];
  assign sk_rise = sk_p[MS] & ~sk_d & ~cs_p[MS];
  assign sk_fall = ~sk_p[MS] & sk_d & ~cs_p[MS];
  assign cs_rise = cs_p[MS] & ~cs_d;
endmodule

// File: rtl/spi_ee_prot.sv
module spi_ee_prot #(
  parameter int AW = 8
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb begin
    case (bp)
      2'd0:    hit = 1'b0;
      2'd1:    hit = &addr[AW-1:AW-2];
      2'd2:    hit = addr[AW-1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    q
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    q <= ram[raddr];
  end
endmodule

// File: rtl/spi_ee_core.sv
module spi_ee_core
  import spi_ee_pkg::*;
#(
  parameter int AW   = 8,
  parameter int PAGE = 16,
  localparam int CW  = $clog2(PAGE + 1),
  localparam int IW  = (PAGE > 1) ? $clog2(PAGE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          si_s,
  input  logic          wp_s,
  input  logic          cs_n_s,
  input  logic          sk_rise,
  input  logic          sk_fall,
  input  logic          cs_rise,
  input  logic [7:0]    ram_q,
  input  logic          wr_prot,
  output logic [AW-1:0] ram_raddr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic [1:0]    bp,
  output logic          so_q,
  output logic          so_en
);
  logic [2:0]    bitc;
  logic [1:0]    bytec;
  logic [7:0]    shreg, sh_next, op, addr_hi, sr_new, oreg;
  logic          op_ok, load_pend, sr_got, wel, pe;
  logic [AW-1:0] ptr, wbase;
  logic [CW-1:0] wcnt, cm_idx, cm_num;
  logic          cm_run;
  logic [7:0]    pbuf [PAGE];
  logic [15:0]   addr_full;
  logic [7:0]    status;

  assign sh_next   = {shreg[6:0], si_s};
  assign addr_full = {addr_hi, sh_next};
  assign status    = sr_pack(pe, bp, wel);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitc      <= '0;
      bytec     <= '0;
      shreg     <= '0;
      op        <= '0;
      op_ok     <= 1'b0;
      addr_hi   <= '0;
      sr_new    <= '0;
      sr_got    <= 1'b0;
      load_pend <= 1'b0;
      oreg      <= '0;
      so_en     <= 1'b0;
      ptr       <= '0;
      wbase     <= '0;
      wcnt      <= '0;
      wel       <= 1'b0;
      pe        <= 1'b0;
      bp        <= '0;
      cm_run    <= 1'b0;
      cm_idx    <= '0;
      cm_num    <= '0;
    end else begin
      if (cs_n_s) begin
        bitc      <= '0;
        bytec     <= '0;
        load_pend <= 1'b0;
        so_en     <= 1'b0;
        op_ok     <= 1'b0;
        sr_got    <= 1'b0;
        wcnt      <= '0;
      end else begin
        if (sk_rise) begin
          shreg <= sh_next;
          bitc  <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            if (bytec != 2'd3) bytec <= bytec + 2'd1;
            case (bytec)
              2'd0: begin
                op    <= sh_next;
                op_ok <= 1'b1;
                if (sh_next == OP_RDSR) load_pend <= 1'b1;
              end
              2'd1: begin
                addr_hi <= sh_next;
                if (op == OP_WRSR) begin
                  sr_new <= sh_next;
                  sr_got <= 1'b1;
                end
                if (op == OP_RDSR) load_pend <= 1'b1;
              end
              2'd2: begin
                if (op == OP_READ) begin
                  ptr       <= addr_full[AW-1:0];
                  load_pend <= 1'b1;
                end
                if (op == OP_WRITE) wbase <= addr_full[AW-1:0];
                if (op == OP_RDSR) load_pend <= 1'b1;
              end
              default: begin
                if (op == OP_READ || op == OP_RDSR) load_pend <= 1'b1;
                if (op == OP_WRITE && wcnt < CW'(PAGE)) begin
                  pbuf[wcnt[IW-1:0]] <= sh_next;
                  wcnt <= wcnt + CW'(1);
                end
              end
            endcase
          end
        end
        if (sk_fall) begin
          if (load_pend) begin
            oreg      <= (op == OP_RDSR) ? status : ram_q;
            load_pend <= 1'b0;
            so_en     <= 1'b1;
            if (op == OP_READ) ptr <= ptr + AW'(1);
          end else begin
            oreg <= {oreg[6:0], 1'b0};
          end
        end
      end

      if (cs_rise && op_ok) begin
        case (op)
          OP_WREN: wel <= 1'b1;
          OP_WRDI: wel <= 1'b0;
          OP_WRITE: if (wcnt != '0) begin
            wel <= 1'b0;
            if (wel) begin
              cm_run <= 1'b1;
              cm_idx <= '0;
              cm_num <= wcnt;
            end
          end
          OP_WRSR: if (sr_got) begin
            wel <= 1'b0;
            if (wel && (!pe || wp_s)) begin
              pe <= sr_new[SR_PE];
              bp <= sr_new[SR_BPH:SR_BPL];
            end
          end
          default: ;
        endcase
      end

      if (cm_run) begin
        cm_idx <= cm_idx + CW'(1);
        if (cm_idx == cm_num - CW'(1)) cm_run <= 1'b0;
      end
    end
  end

  assign ram_raddr = ptr;
  assign ram_waddr = wbase + AW'(cm_idx);
  assign ram_wdata = pbuf[cm_idx[IW-1:0]];
  assign ram_we    = cm_run & ~wr_prot;
  assign so_q      = oreg[7];

  // R2: the latch can only be set at the end of a frame
  a_r2_wel_on_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(cs_rise));

  // R9: protect fields change only while the latch was set
  a_r9_sr_gate: assert property (@(posedge clk) disable iff (rst)
    !$stable({pe, bp}) |-> $past(wel));

  // R10: a finished data-carrying write drops the latch
  a_r10_wel_clear: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && op_ok && op == OP_WRITE && wcnt != '0) |=> !wel);

  // R7: commit never walks past the captured byte count
  a_r7_commit_bound: assert property (@(posedge clk) disable iff (rst)
    cm_run |-> (cm_idx < cm_num && cm_num <= CW'(PAGE)));
endmodule

// File: rtl/spi_ee_top.sv
module spi_ee_top #(
  parameter int DEPTH  = 256,
  parameter int PAGE   = 16,
  parameter int SYNC   = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst,
  input  logic sk,
  input  logic cs_n,
  input  logic si,
  input  logic wp,
  output wire  so
);
  logic          si_s, wp_s, cs_n_s, sk_rise, sk_fall, cs_rise;
  logic [7:0]    ram_q, ram_wdata;
  logic [AW-1:0] ram_raddr, ram_waddr;
  logic          ram_we, prot_hit, so_q, so_en;
  logic [1:0]    bp;

  spi_ee_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .sk_i(sk), .cs_n_i(cs_n), .si_i(si), .wp_i(wp),
    .si_s(si_s), .wp_s(wp_s), .cs_n_s(cs_n_s),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_rise(cs_rise)
  );

  spi_ee_prot #(.AW(AW)) u_prot (
    .bp(bp), .addr(ram_waddr), .hit(prot_hit)
  );

  spi_ee_core #(.AW(AW), .PAGE(PAGE)) u_core (
    .clk(clk), .rst(rst), .si_s(si_s), .wp_s(wp_s), .cs_n_s(cs_n_s),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_rise(cs_rise),
    .ram_q(ram_q), .wr_prot(prot_hit), .ram_raddr(ram_raddr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .bp(bp), .so_q(so_q), .so_en(so_en)
  );

  spi_ee_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .q(ram_q)
  );

  assign so = so_en ? so_q : 1'bz;

  // R8: the array port never writes inside the fenced region
  a_r8_no_prot_write: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !prot_hit);

  // R11: output driver is off while select stays high
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && $past(cs_n_s)) |-> !so_en);
endmodule

// File: tb/sim_spi_ee_top.sv
module sim_spi_ee_top;
  localparam int DEPTH = 16;
  localparam int PAGE  = 4;

  logic clk = 1'b0, rst = 1'b1, sk = 1'b0, cs_n = 1'b1, si = 1'b0, wp = 1'b1;
  wire  so;
  int   total = 0, bad = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] rb  [24];

  always #2 clk = ~clk;

  spi_ee_top #(.DEPTH(DEPTH), .PAGE(PAGE)) u0 (
    .clk(clk), .rst(rst), .sk(sk), .cs_n(cs_n), .si(si), .wp(wp), .so(so)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      tick(8);
      rx[i] = so;
      sk = 1'b1;
      tick(8);
      sk = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic fstart();
    cs_n = 1'b0;
    tick(8);
  endtask

  task automatic fend();
    tick(8);
    cs_n = 1'b1;
    tick(24);
  endtask

  task automatic op1(input logic [7:0] opc);
    logic [7:0] d;
    fstart(); xb(opc, d); fend();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    fstart(); xb(8'h05, d); xb(8'h00, v); fend();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    fstart(); xb(8'h01, d); xb(v, d); fend();
  endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    fstart(); xb(8'h02, d); xb(a[15:8], d); xb(a[7:0], d); xb(v, d); fend();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] d;
    fstart(); xb(8'h03, d); xb(a[15:8], d); xb(a[7:0], d);
    for (int i = 0; i < n; i++) xb(8'h00, rb[i]);
    fend();
  endtask

  function automatic logic isprot(input int b, input int a);
    return (b == 3) || (b == 2 && a >= DEPTH / 2) || (b == 1 && a >= 3 * DEPTH / 4);
  endfunction

  task automatic check_all(input string tag);
    rd(16'h0000, DEPTH);
    for (int i = 0; i < DEPTH; i++) chk(tag, {24'd0, rb[i]}, {24'd0, mdl[i]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    tick(10);
    rst = 1'b0;
    tick(10);
    chk("R11 reset so z", {31'd0, so === 1'bz}, 32'd1);
    rdsr(s);
    chk("R1 reset status", {24'd0, s}, 32'h00);
    chk("R11 so z after frame", {31'd0, so === 1'bz}, 32'd1);

    // R2: latch set and clear
    op1(8'h06); rdsr(s); chk("R2 wren", {24'd0, s}, 32'h02);
    op1(8'h04); rdsr(s); chk("R2 wrdi", {24'd0, s}, 32'h00);

    // R7: fill array in full pages
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      op1(8'h06);
      fstart(); xb(8'h02, d); xb(8'h00, d); xb(8'(p * PAGE), d);
      for (int k = 0; k < PAGE; k++) begin
        mdl[p * PAGE + k] = 8'((p * PAGE + k) * 37 + 5);
        xb(mdl[p * PAGE + k], d);
      end
      fend();
      rdsr(s); chk("R10 wel cleared after write", {24'd0, s}, 32'h00);
    end
    check_all("R4 R7 fill readback");

    // R2: write in the same frame as the latch set must not land
    fstart(); xb(8'h06, d); xb(8'h02, d); xb(8'h00, d); xb(8'h03, d); xb(8'hAA, d); fend();
    rdsr(s); chk("R2 latch after combined frame", {24'd0, s}, 32'h02);
    rd(16'h0003, 1); chk("R2 combined frame no write", {24'd0, rb[0]}, {24'd0, mdl[3]});
    op1(8'h04);

    // R3: write without latch
    wr1(16'h0005, 8'h11);
    rd(16'h0005, 1); chk("R3 no latch no write", {24'd0, rb[0]}, {24'd0, mdl[5]});

    // R4: upper address bits ignored
    rd(16'hAB07, 1); chk("R4 upper bits ignored", {24'd0, rb[0]}, {24'd0, mdl[7]});

    // R5: sequential read with wrap
    rd(16'd13, 20);
    for (int i = 0; i < 20; i++) chk("R5 wrap read", {24'd0, rb[i]}, {24'd0, mdl[(13 + i) % DEPTH]});

    // R7: over-long write wraps at array top and drops extra bytes
    op1(8'h06);
    fstart(); xb(8'h02, d); xb(8'h00, d); xb(8'd14, d);
    for (int k = 0; k < 6; k++) begin
      if (k < PAGE) mdl[(14 + k) % DEPTH] = 8'hC0 + 8'(k);
      xb(8'hC0 + 8'(k), d);
    end
    fend();
    // R7: trailing partial byte dropped
    op1(8'h06);
    fstart(); xb(8'h02, d); xb(8'h00, d); xb(8'd2, d); xb(8'h9E, d); xbits(8'hFF, 3, d); fend();
    mdl[2] = 8'h9E;
    check_all("R7 page limit and partial");

    // R10: address-only write frame keeps the latch
    op1(8'h06);
    fstart(); xb(8'h02, d); xb(8'h00, d); xb(8'h04, d); fend();
    rdsr(s); chk("R10 no data keeps latch", {24'd0, s}, 32'h02);
    op1(8'h04);

    // R6: status repeats while clocked
    op1(8'h06);
    fstart(); xb(8'h05, d);
    for (int i = 0; i < 3; i++) begin
      xb(8'h00, s); chk("R6 repeated status", {24'd0, s}, 32'h02);
    end
    fend();
    op1(8'h04);

    // R8: every protect level over every address
    for (int b = 0; b < 4; b++) begin
      op1(8'h06); wrsr(8'(b << 2));
      rdsr(s); chk("R6 R9 bp field", {24'd0, s}, 32'(b << 2));
      for (int a = 0; a < DEPTH; a++) begin
        op1(8'h06);
        wr1(16'(a), 8'((b * 16 + a) ^ 8'h5A));
        if (!isprot(b, a)) mdl[a] = 8'((b * 16 + a) ^ 8'h5A);
      end
      rdsr(s); chk("R10 wel cleared after gated write", {24'd0, s}, 32'(b << 2));
      check_all("R8 protect sweep");
    end

    // R9: status write gating table
    op1(8'h06); wrsr(8'h00);
    for (int pe = 0; pe < 2; pe++)
      for (int pin = 0; pin < 2; pin++)
        for (int we = 0; we < 2; we++) begin
          logic [7:0] base, want;
          base = pe ? 8'h84 : 8'h04;
          want = pe ? 8'h88 : 8'h08;
          wp = 1'b1; tick(4);
          op1(8'h06); wrsr(base);
          wp = pin[0]; tick(4);
          if (we != 0) op1(8'h06);
          wrsr(want);
          rdsr(s);
          chk("R9 R10 status gate", {24'd0, s},
              {24'd0, ((we != 0) && (pe == 0 || pin != 0)) ? want : base});
          wp = 1'b1; tick(4);
          op1(8'h06); wrsr(8'h00);
        end
    check_all("R9 array untouched");
    chk("R11 so z at end", {31'd0, so === 1'bz}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule